// File: doc/BRIEF.md
# Wide register write collector

This block accepts 32-bit host writes and turns them into whole-register updates for 128-bit control registers and 64-bit SRAM words. Each dword lands in one shared collector holding a target address, a per-dword valid mask and up to 128 bits of data. The wide target is updated, and a commit pulse shows it on the commit port, only once every dword of that target has arrived. A dword aimed at another target throws the partial contents away and starts over at the new address. Host software therefore has to serialise its wide accesses: interleaved sequences lose data.

The address space is split into per-queue pages 0x2000 bytes apart, followed by the SRAM window. Each page holds two 32-bit registers that bypass the collector, and two write-only 128-bit descriptor pointers. A write to the top dword of a descriptor pointer always commits it. Low dwords the collector did not hold for that pointer are filled with zero, so a single 32-bit store is enough to advance a queue. The wide control registers live in page 0 only. A parameter keeps an old silicon defect: a write to the page-0 timer register empties the collector. Reads are dword-wide, have one cycle of latency and return stored contents directly.

Top module: `wide_wr_collector`

## Requirements
- R1: A wide control register (page 0, byte offset 16*i for i < NREG) commits only when all four dwords have been written, in any order, with no write to another target in between. The cycle after the completing write, cm_valid is high for one cycle with cm_addr equal to the register base and cm_data holding dword k in bits 32k+31:32k. No commit happens before that.
- R2: An SRAM word (byte address SRAM base + 8*j, with SRAM base = PAGES*0x2000) commits after both of its dwords have been written. cm_data[63:0] holds the word and cm_data[127:64] is zero.
- R3: A control-register or SRAM dword whose target differs from the one the collector holds empties the collector and starts collecting at the new target. An interleaved sequence therefore produces no commit for the abandoned target, and that target keeps its old value.
- R4: A write to the top dword of a descriptor pointer (page offset 0x83C or 0xA1C) always commits the pointer at base 0x830 or 0xA10 in the next cycle, with the written data in bits 127:96. A low dword is taken from the collector only if the collector held this pointer and that dword was written; every other low dword is zero. The collector is emptied only when it held this pointer.
- R5: A write to a lower dword of a descriptor pointer is discarded while the collector holds a different target. The collector contents stay unchanged and no commit occurs.
- R6: Byte address = page*0x2000 + offset for the per-queue registers, for every page below PAGES. Offsets that map to nothing are ignored on write (no commit) and read as zero.
- R7: Writes to page offsets 0x400 (event pointer) and 0x420 (timer command) are stored directly and commit in the next cycle with the data in cm_data[31:0] and the write address on cm_addr. The collector is not touched, apart from the case in R8.
- R8: With QUIRK_EN = 1, a write to offset 0x420 in page 0 empties the collector; the same write in any other page does not. With QUIRK_EN = 0 it never does.
- R9: A read returns its data one cycle after rd_en, with rd_valid high for that cycle. It gives the stored dword of a control register, SRAM word, event pointer or timer command as it was before any write in the same cycle. Descriptor pointers read as zero.
- R10: After reset the collector is empty, no commit or read result is signalled, and all readable storage is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host dword write strobe |
| wr_addr | input | AW | Write byte address (dword aligned) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Host dword read strobe |
| rd_addr | input | AW | Read byte address (dword aligned) |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| cm_valid | output | 1 | Commit pulse for a wide or direct register update |
| cm_addr | output | AW | Base byte address of the committed target |
| cm_data | output | 128 | Committed value, dword k in bits 32k+31:32k |

## Verification
The bench builds the block twice with PAGES = 4, NREG = 4 and NSRAM = 8. One copy keeps QUIRK_EN = 1 and is compared against a behavioural model on every clock. The other has QUIRK_EN = 0 and is driven with the same stimulus, so the timer-register write that empties the collector in page 0 can be set against the copy where it does not. Four pages make page arithmetic visible beyond page 0, including the absence of control registers there. A random phase over a small pool of addresses mixes interleaved writes, descriptor writes and direct writes with concurrent reads.

// File: rtl/wide_wr_collector.sv
module wide_wr_collector #(
  parameter int PAGES    = 4,
  parameter int NREG     = 4,
  parameter int NSRAM    = 8,
  parameter int QUIRK_EN = 1,
  localparam int AW      = $clog2(PAGES * 8192 + NSRAM * 8 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic          cm_valid,
  output logic [AW-1:0] cm_addr,
  output logic [127:0]  cm_data
);
  localparam int PW  = PAGES > 1 ? $clog2(PAGES) : 1;
  localparam int RIW = NREG  > 1 ? $clog2(NREG)  : 1;
  localparam int SIW = NSRAM > 1 ? $clog2(NSRAM) : 1;
  localparam logic [AW-1:0] SRAM_LO = AW'(PAGES * 8192);
  localparam logic [AW-1:0] SRAM_HI = AW'(PAGES * 8192 + NSRAM * 8);
  localparam logic [12:0]   NREG_END = 13'(NREG * 16);

  typedef struct packed {
    logic          norm;
    logic          sram;
    logic          evq;
    logic          tmr;
    logic          desc;
    logic [AW-1:0] base;
    logic [1:0]    k;
    logic [PW-1:0] page;
    logic [RIW-1:0] nidx;
    logic [SIW-1:0] sidx;
  } dec_t;

  function automatic dec_t decode(input logic [AW-1:0] a);
    dec_t d;
    logic [12:0] off;
    d = '0;
    off = a[12:0];
    d.k = a[3:2];
    d.page = PW'(a >> 13);
    d.nidx = RIW'(a >> 4);
    d.sidx = SIW'((a - SRAM_LO) >> 3);
    if (a < SRAM_LO) begin
      d.norm = ((a >> 13) == '0) && (off < NREG_END);
      d.evq  = (off == 13'h400);
      d.tmr  = (off == 13'h420);
      d.desc = (off[12:4] == 9'h083) || (off[12:4] == 9'h0A1);
      d.base = {a[AW-1:4], 4'b0};
    end else if (a < SRAM_HI) begin
      d.sram = 1'b1;
      d.k    = {1'b0, a[2]};
      d.base = {a[AW-1:3], 3'b0};
    end
    return d;
  endfunction

  dec_t wd, rd;
  assign wd = decode(wr_addr);
  assign rd = decode(rd_addr);

  logic [AW-1:0]    col_tgt;
  logic [3:0]       col_mask;
  logic [3:0][31:0] col_data;

  logic [127:0] nreg [NREG];
  logic [63:0]  smem [NSRAM];
  logic [31:0]  evq  [PAGES];
  logic [31:0]  tmr  [PAGES];

  logic             hit, own, full;
  logic [3:0]       nmask;
  logic [3:0][31:0] fd;
  logic [95:0]      dlo;

  assign own   = (col_mask != 4'b0) && (col_tgt == wd.base);
  assign hit   = (col_mask == 4'b0) || (col_tgt == wd.base);
  assign nmask = (hit ? col_mask : 4'b0) | (4'b1 << wd.k);
  assign full  = wd.sram ? (nmask[1:0] == 2'b11) : (nmask == 4'hF);

  always_comb begin
    fd = col_data;
    fd[wd.k] = wr_data;
    for (int j = 0; j < 3; j++)
      dlo[32*j +: 32] = (own && col_mask[j]) ? col_data[j] : 32'b0;
  end

  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    if (rd.norm)      rmux = nreg[rd.nidx][{rd.k, 5'b0} +: 32];
    else if (rd.sram) rmux = smem[rd.sidx][{rd.k[0], 5'b0} +: 32];
    else if (rd.evq)  rmux = evq[rd.page];
    else if (rd.tmr)  rmux = tmr[rd.page];
    else if (rd.desc) rmux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_tgt  <= '0;
      col_mask <= '0;
      col_data <= '0;
      cm_valid <= 1'b0;
      cm_addr  <= '0;
      cm_data  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      for (int i = 0; i < NREG; i++)  nreg[i] <= '0;
      for (int i = 0; i < NSRAM; i++) smem[i] <= '0;
      for (int i = 0; i < PAGES; i++) begin
        evq[i] <= '0;
        tmr[i] <= '0;
      end
    end else begin
      cm_valid <= 1'b0;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rmux;
      if (wr_valid) begin
        if (wd.evq || wd.tmr) begin
          if (wd.evq) evq[wd.page] <= wr_data;
          else        tmr[wd.page] <= wr_data;
          cm_valid <= 1'b1;
          cm_addr  <= wr_addr;
          cm_data  <= {96'b0, wr_data};
          if (QUIRK_EN != 0 && wd.tmr && wd.page == '0) col_mask <= '0;
        end else if (wd.desc) begin
          if (wd.k == 2'd3) begin
            cm_valid <= 1'b1;
            cm_addr  <= wd.base;
            cm_data  <= {wr_data, dlo};
            if (own) col_mask <= '0;
          end else if (hit) begin
            col_tgt <= wd.base;
            col_mask <= nmask;
            col_data[wd.k] <= wr_data;
          end
        end else if (wd.norm || wd.sram) begin
          col_tgt <= wd.base;
          if (full) begin
            col_mask <= '0;
            cm_valid <= 1'b1;
            cm_addr  <= wd.base;
            if (wd.norm) begin
              nreg[wd.nidx] <= fd;
              cm_data <= fd;
            end else begin
              smem[wd.sidx] <= {fd[1], fd[0]};
              cm_data <= {64'b0, fd[1], fd[0]};
            end
          end else begin
            col_mask <= nmask;
            col_data[wd.k] <= wr_data;
          end
        end
      end
    end
  end

  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_commit_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> $past(wr_valid));

  p_no_partial_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wd.norm && nmask != 4'hF) |=> !cm_valid);

  p_desc_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wd.desc && wd.k == 2'd3) |=>
      (cm_valid && cm_data[127:96] == $past(wr_data) && cm_addr == $past(wd.base)));

  p_desc_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wd.desc && wd.k != 2'd3 && col_mask != 4'b0 && col_tgt != wd.base) |=>
      ($stable(col_mask) && $stable(col_tgt) && !cm_valid));

  p_quirk_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (QUIRK_EN != 0 && wr_valid && wd.tmr && wd.page == '0) |=> (col_mask == 4'b0));

  p_direct_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wd.evq || (wd.tmr && (QUIRK_EN == 0 || wd.page != '0)))) |=>
      ($stable(col_mask) && $stable(col_tgt)));
endmodule

// File: tb/wide_wr_collector_bench.sv
`timescale 1ns/1ps
module wide_wr_collector_bench;
  localparam int AW = 16;
  localparam int PAGES = 4, NREG = 4, NSRAM = 8;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic rd_valid, cm_valid, rd_valid_nq, cm_valid_nq;
  logic [31:0] rd_data, rd_data_nq;
  logic [AW-1:0] cm_addr, cm_addr_nq;
  logic [127:0] cm_data, cm_data_nq;

  always #2.5 clk = ~clk;

  wide_wr_collector #(.PAGES(PAGES), .NREG(NREG), .NSRAM(NSRAM), .QUIRK_EN(1)) u_wide_wr_collector (
    .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .rd_en, .rd_addr,
    .rd_valid, .rd_data, .cm_valid, .cm_addr, .cm_data);
  wide_wr_collector #(.PAGES(PAGES), .NREG(NREG), .NSRAM(NSRAM), .QUIRK_EN(0)) u_wide_wr_collector_nq (
    .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .rd_en, .rd_addr,
    .rd_valid(rd_valid_nq), .rd_data(rd_data_nq), .cm_valid(cm_valid_nq),
    .cm_addr(cm_addr_nq), .cm_data(cm_data_nq));

  int checks = 0, failures = 0;
  string cur_req = "R10";
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [127:0] mw [int];
  logic [31:0]  m32 [int];
  int ctgt = 0;
  bit [3:0] cmask = 0;
  logic [31:0] cdat [4];
  bit exp_cv = 0, exp_rv = 0;
  int exp_ca = 0;
  logic [127:0] exp_cd = 0;
  logic [31:0] exp_rd = 0;

  function automatic void mdec(input int a, output int cls, output int base, output int k, output int pg);
    int off;
    cls = 0; base = 0; k = (a % 16) / 4; pg = a / 8192; off = a % 8192;
    if (a < PAGES * 8192) begin
      base = a - a % 16;
      if (pg == 0 && off < NREG * 16) cls = 1;
      else if (off == 'h400) cls = 3;
      else if (off == 'h420) cls = 4;
      else if (off / 16 == 'h83 || off / 16 == 'hA1) cls = 5;
    end else if (a < PAGES * 8192 + NSRAM * 8) begin
      cls = 2; base = a - a % 8; k = (a % 8) / 4;
    end
  endfunction

  function automatic logic [31:0] mread(input int a);
    int cls, base, k, pg;
    mdec(a, cls, base, k, pg);
    if ((cls == 1 || cls == 2) && mw.exists(base)) return mw[base][32*k +: 32];
    if ((cls == 3 || cls == 4) && m32.exists(a)) return m32[a];
    return 32'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mw.delete(); m32.delete(); cmask = 0; ctgt = 0;
      exp_cv = 0; exp_rv = 0;
    end else begin
      int cls, base, k, pg, a;
      logic [127:0] v;
      exp_rv = rd_en;
      if (rd_en) exp_rd = mread(int'(rd_addr));
      exp_cv = 0;
      if (wr_valid) begin
        a = int'(wr_addr);
        mdec(a, cls, base, k, pg);
        if (cls == 1 || cls == 2) begin
          if (cmask != 0 && ctgt != base) cmask = 0;
          ctgt = base; cdat[k] = wr_data; cmask[k] = 1;
          if ((cls == 1 && cmask == 4'hF) || (cls == 2 && cmask == 4'h3)) begin
            v = 0;
            for (int j = 0; j < 4; j++) if (cls == 1 || j < 2) v[32*j +: 32] = cdat[j];
            mw[base] = v; cmask = 0;
            exp_cv = 1; exp_ca = base; exp_cd = v;
          end
        end else if (cls == 5) begin
          if (k == 3) begin
            v = 0; v[127:96] = wr_data;
            if (cmask != 0 && ctgt == base) begin
              for (int j = 0; j < 3; j++) if (cmask[j]) v[32*j +: 32] = cdat[j];
              cmask = 0;
            end
            exp_cv = 1; exp_ca = base; exp_cd = v;
          end else if (cmask == 0 || ctgt == base) begin
            ctgt = base; cdat[k] = wr_data; cmask[k] = 1;
          end
        end else if (cls == 3 || cls == 4) begin
          m32[a] = wr_data;
          exp_cv = 1; exp_ca = a; exp_cd = {96'b0, wr_data};
          if (cls == 4 && pg == 0) cmask = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cm_valid == exp_cv && (!exp_cv || (int'(cm_addr) == exp_ca && cm_data == exp_cd)),
          {cur_req, " commit"}, {cm_valid, cm_data[126:0]}, {exp_cv, exp_cd[126:0]});
      chk(rd_valid == exp_rv && (!exp_rv || rd_data == exp_rd),
          {cur_req, " R9 read"}, {95'b0, rd_valid, rd_data}, {95'b0, exp_rv, exp_rd});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rdx(input int a, input logic [31:0] exp, input string req);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid && rd_data == exp, req, {96'b0, rd_data}, {96'b0, exp});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R10";
    chk(!cm_valid && !rd_valid, "R10 idle after reset", {126'b0, cm_valid, rd_valid}, 0);
    rdx('h10, 0, "R10 storage zero");

    cur_req = "R1";
    wr('h18, 32'hA2); wr('h10, 32'hA0); wr('h1C, 32'hA3);
    chk(!cm_valid, "R1 no early commit", {127'b0, cm_valid}, 0);
    wr('h14, 32'hA1);
    chk(cm_valid && cm_addr == 'h10 && cm_data == {32'hA3, 32'hA2, 32'hA1, 32'hA0},
        "R1 commit", cm_data, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    rdx('h18, 32'hA2, "R1 readback");

    cur_req = "R2";
    wr('h801C, 32'hB1); wr('h8018, 32'hB0);
    chk(cm_valid && cm_addr == 'h8018 && cm_data == {64'b0, 32'hB1, 32'hB0},
        "R2 sram commit", cm_data, {64'b0, 32'hB1, 32'hB0});
    rdx('h801C, 32'hB1, "R2 readback");

    cur_req = "R3";
    wr('h00, 32'hC0); wr('h04, 32'hC1); wr('h20, 32'hD0); wr('h08, 32'hC2); wr('h0C, 32'hC3);
    chk(!cm_valid, "R3 interleave loses write", {127'b0, cm_valid}, 0);
    rdx('h00, 0, "R3 abandoned target unchanged");
    wr('h00, 32'hC0); wr('h04, 32'hC1);
    chk(cm_valid && cm_data == {32'hC3, 32'hC2, 32'hC1, 32'hC0}, "R3 restart completes",
        cm_data, {32'hC3, 32'hC2, 32'hC1, 32'hC0});

    cur_req = "R4";
    wr('h2830, 32'hE0); wr('h2834, 32'hE1); wr('h283C, 32'hE3);
    chk(cm_valid && cm_addr == 'h2830 && cm_data == {32'hE3, 32'h0, 32'hE1, 32'hE0},
        "R4 top commit zero fill", cm_data, {32'hE3, 32'h0, 32'hE1, 32'hE0});
    wr('h4A1C, 32'hF3);
    chk(cm_valid && cm_addr == 'h4A10 && cm_data == {32'hF3, 96'b0}, "R4 top only",
        cm_data, {32'hF3, 96'b0});

    cur_req = "R5";
    wr('h30, 32'h30); wr('h0834, 32'h99);
    chk(!cm_valid, "R5 low dword discarded", {127'b0, cm_valid}, 0);
    wr('h083C, 32'h9F);
    chk(cm_valid && cm_data == {32'h9F, 96'b0}, "R5 R4 no foreign data", cm_data, {32'h9F, 96'b0});
    wr('h34, 32'h31); wr('h38, 32'h32); wr('h3C, 32'h33);
    chk(cm_valid && cm_data == {32'h33, 32'h32, 32'h31, 32'h30}, "R5 collector kept",
        cm_data, {32'h33, 32'h32, 32'h31, 32'h30});

    cur_req = "R6";
    wr('h6400, 32'h64);
    rdx('h6400, 32'h64, "R6 page 3 register");
    rdx('h0400, 0, "R6 page 0 separate");
    wr('h6A1C, 32'h6A);
    chk(cm_valid && cm_addr == 'h6A10, "R6 page 3 descriptor", {112'b0, cm_addr}, 'h6A10);
    wr('h2000, 32'h55);
    chk(!cm_valid, "R6 no control regs beyond page 0", {127'b0, cm_valid}, 0);
    rdx('h2000, 0, "R6 unmapped reads zero");

    cur_req = "R7";
    wr('h20, 32'h20); wr('h0400, 32'h40);
    chk(cm_valid && cm_addr == 'h400 && cm_data == {96'b0, 32'h40}, "R7 direct commit",
        cm_data, {96'b0, 32'h40});
    wr('h24, 32'h21); wr('h28, 32'h22); wr('h2C, 32'h23);
    chk(cm_valid && cm_data == {32'h23, 32'h22, 32'h21, 32'h20}, "R7 collector untouched",
        cm_data, {32'h23, 32'h22, 32'h21, 32'h20});
    rdx('h0400, 32'h40, "R7 readback");

    cur_req = "R8";
    wr('h10, 32'h70); wr('h14, 32'h71); wr('h18, 32'h72); wr('h2420, 32'h11);
    wr('h1C, 32'h73);
    chk(cm_valid && cm_data == {32'h73, 32'h72, 32'h71, 32'h70}, "R8 other page no clear",
        cm_data, {32'h73, 32'h72, 32'h71, 32'h70});
    wr('h10, 32'h80); wr('h14, 32'h81); wr('h18, 32'h82); wr('h0420, 32'h12);
    wr('h1C, 32'h83);
    chk(!cm_valid, "R8 page 0 quirk clears", {127'b0, cm_valid}, 0);
    chk(cm_valid_nq && cm_data_nq == {32'h83, 32'h82, 32'h81, 32'h80}, "R8 quirk off keeps",
        cm_data_nq, {32'h83, 32'h82, 32'h81, 32'h80});

    cur_req = "R9";
    rdx('h0830, 0, "R9 descriptor reads zero");
    rdx('h0A1C, 0, "R9 descriptor top reads zero");
    rdx('h8018, 32'hB0, "R9 sram dword 0");

    cur_req = "R3 R4 R5 random";
    for (int i = 0; i < 3000; i++) begin
      int r, a;
      r = $urandom % 8;
      case (r)
        0, 1: a = 16 * ($urandom % NREG) + 4 * ($urandom % 4);
        2:    a = 'h8000 + 8 * ($urandom % NSRAM) + 4 * ($urandom % 2);
        3:    a = 'h0830 + 4 * ($urandom % 4);
        4:    a = 'h2A10 + 4 * ($urandom % 4);
        5:    a = 'h0420;
        6:    a = 'h2400;
        default: a = 'h0010 + 4 * ($urandom % 4);
      endcase
      wr_valid = ($urandom % 4) != 0; wr_addr = AW'(a); wr_data = $urandom;
      rd_en = $urandom % 2;
      rd_addr = AW'(($urandom % 2) ? 16 * ($urandom % NREG) + 4 * ($urandom % 4)
                                   : 'h8000 + 4 * ($urandom % 16));
      @(negedge clk);
    end
    wr_valid = 0; rd_en = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule